// File: doc/BRIEF.md
# TDM Bus Slot Sequencer

This block is the bus master's time-division sequencer for a shared bus. Each major period is split into a fixed number of equal timeslots, each a fixed number of clocks long. The owner of every slot comes from a table fixed at design time, so nothing is arbitrated and each unit knows in advance which slots are its own. Every slot names a source unit and a destination unit, because the master starts every transfer, including transfers from one slave to another. A unit's slots are interleaved through the period rather than bunched together.

An external period-start strobe re-phases the sequence at slot 0. A run of periods forms a superframe of 19 periods, tracked by a period counter. One spare slot per period is passed to different occasional users in turn, chosen by the period count. Each slot opens with a short guard window in which no grant is given, leaving time for the bus to turn around. A strobe that arrives while a period is still running restarts the sequence at once and raises a sticky overrun flag.

Top module: `tdm_slot_sequencer`

## Requirements
- R1: After reset, in_period, guard, overrun and both grant vectors are 0, slot_idx is 0 and period_idx is 18 (superframe length minus one).
- R2: A high period_start sampled while idle starts slot 0 on the next clock. Each slot lasts 6 clocks, slots run 0 to 7 in order, and after the last clock of slot 7 the block goes idle (in_period 0, no grants) until the next strobe.
- R3: During the first 2 clocks of every slot, guard is 1 and both grant vectors are 0. During the remaining clocks guard is 0.
- R4: Grant vectors are one-hot by unit ID: unit k drives bit k-1, and ID 0 means no grant. Even slots have source unit 4 (src_grant 4'b1000) and destination unit 1 (dst_grant 4'b0001). Odd slots other than slot 7 have source unit 1 and destination unit 3 (dst_grant 4'b0100).
- R5: Slot 7 is the spare slot. Its owner depends on period_idx mod 3: 0 gives source 2, destination 1; 1 gives source 1, destination 2; 2 gives no grant.
- R6: period_idx increments by one on each accepted strobe, wraps from 18 to 0, and holds otherwise.
- R7: A strobe sampled while a period runs, at any clock other than the last clock of slot 7, restarts at slot 0, clock 0 on the next clock and sets overrun. Overrun stays set until reset.
- R8: A strobe sampled on the last clock of slot 7 starts the next period with no gap and does not set overrun.
- R9: At most one bit of src_grant and at most one bit of dst_grant is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_start | input | 1 | External strobe that marks the start of a period |
| src_grant | output | 4 | One-hot grant to the source unit of the current slot |
| dst_grant | output | 4 | One-hot grant to the destination unit of the current slot |
| slot_idx | output | 3 | Index of the current slot |
| period_idx | output | 5 | Position of the current period in the superframe |
| guard | output | 1 | High during the turnaround window at the start of a slot |
| in_period | output | 1 | High while the slots of a period are running |
| overrun | output | 1 | Sticky flag: a strobe arrived before the period had finished |

## Verification
The hardest case to reach is the boundary between two periods. A strobe landing exactly on the final clock of slot 7 must chain the periods with no overrun. A strobe one clock earlier must restart the sequence and flag an overrun. The bench asserts the strobe from inside its per-clock walk through a period, so it hits that exact clock and the clock in the middle of slot 3. Showing all three spare-slot owners and the wrap from 18 to 0 takes many periods. The bench chains three periods for the owners, then steps the counter with isolated strobes until it wraps, and checks the spare slot again just after the wrap.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int NUM_UNITS = 4;
    localparam int UID_W     = $clog2(NUM_UNITS + 1);
    localparam int SPARE_ROT = 3;

    typedef logic [UID_W-1:0] uid_t;

    typedef struct packed {
        uid_t src;
        uid_t dst;
    } route_t;

    // Reserved owners: even slots carry unit 4 -> unit 1, odd slots unit 1 -> unit 3.
    function automatic route_t fixed_route(input int slot);
        route_t r;
        if ((slot % 2) == 0) begin
            r.src = UID_W'(4);
            r.dst = UID_W'(1);
        end else begin
            r.src = UID_W'(1);
            r.dst = UID_W'(3);
        end
        return r;
    endfunction

    // Occasional users of the spare slot, indexed by period position.
    function automatic route_t spare_route(input int rot);
        route_t r;
        case (rot)
            0: begin r.src = UID_W'(2); r.dst = UID_W'(1); end
            1: begin r.src = UID_W'(1); r.dst = UID_W'(2); end
            default: begin r.src = '0; r.dst = '0; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
    parameter int NUM_SLOTS  = 8,
    parameter int SLOT_CLKS  = 6,
    parameter int GUARD_CLKS = 2,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int TICK_W = $clog2(SLOT_CLKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              active,
    output logic [SLOT_W-1:0] slot,
    output logic              guard,
    output logic              overrun
);
    localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(NUM_SLOTS - 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(SLOT_CLKS - 1);
    localparam logic [TICK_W-1:0] GUARD_N   = TICK_W'(GUARD_CLKS);

    logic [TICK_W-1:0] tick;
    logic              tick_last;
    logic              at_end;

    assign tick_last = (tick == TICK_LAST);
    assign at_end    = active && tick_last && (slot == SLOT_LAST);
    assign guard     = active && (tick < GUARD_N);

    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= 1'b0;
            slot    <= '0;
            tick    <= '0;
            overrun <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            slot   <= '0;
            tick   <= '0;
            if (active && !at_end) overrun <= 1'b1;
        end else if (active) begin
            if (tick_last) begin
                tick <= '0;
                if (slot == SLOT_LAST) begin
                    active <= 1'b0;
                    slot   <= '0;
                end else begin
                    slot <= slot + 1'b1;
                end
            end else begin
                tick <= tick + 1'b1;
            end
        end
    end

    AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        start |=> (active && slot == '0 && tick == '0)); // R7

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun); // R7

    AST_CHAIN_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        (start && at_end && !overrun) |=> !overrun); // R8

    AST_SLOT_STEP: assert property (@(posedge clk) disable iff (rst)
        (active && tick_last && slot != SLOT_LAST && !start) |=> (slot == $past(slot) + 1'b1)); // R2

    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst)
        (at_end && !start) |=> !active); // R2

endmodule

// File: rtl/tdm_period_counter.sv
module tdm_period_counter #(
    parameter int SUPER_LEN = 19,
    localparam int PER_W = $clog2(SUPER_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    output logic [PER_W-1:0] period
);
    localparam logic [PER_W-1:0] PER_LAST = PER_W'(SUPER_LEN - 1);

    always_ff @(posedge clk) begin
        if (rst)        period <= PER_LAST;
        else if (start) period <= (period == PER_LAST) ? '0 : period + 1'b1;
    end

    AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(period)); // R6

    AST_PERIOD_WRAP: assert property (@(posedge clk) disable iff (rst)
        (start && period == PER_LAST) |=> (period == '0)); // R6

    AST_PERIOD_RANGE: assert property (@(posedge clk) disable iff (rst)
        period <= PER_LAST); // R6

endmodule

// File: rtl/tdm_owner_lookup.sv
module tdm_owner_lookup
    import tdm_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int SUPER_LEN  = 19,
    parameter int SPARE_SLOT = 7,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int PER_W  = $clog2(SUPER_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enable,
    input  logic [SLOT_W-1:0]    slot,
    input  logic [PER_W-1:0]     period,
    output logic [NUM_UNITS-1:0] src_grant,
    output logic [NUM_UNITS-1:0] dst_grant
);
    route_t route;
    int     rot;

    always_comb begin
        rot = int'(period) % SPARE_ROT;
        if (int'(slot) == SPARE_SLOT) route = spare_route(rot);
        else                          route = fixed_route(int'(slot));
    end

    for (genvar k = 0; k < NUM_UNITS; k++) begin : g_decode
        assign src_grant[k] = enable && (route.src == UID_W'(k + 1));
        assign dst_grant[k] = enable && (route.dst == UID_W'(k + 1));
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_grant) && $onehot0(dst_grant)); // R9

    AST_SRC_DST_PAIRED: assert property (@(posedge clk) disable iff (rst)
        ($countones(src_grant) == $countones(dst_grant))); // R5

endmodule

// File: rtl/tdm_slot_sequencer.sv
module tdm_slot_sequencer
    import tdm_pkg::*;
#(
    parameter int NUM_SLOTS  = 8,
    parameter int SLOT_CLKS  = 6,
    parameter int GUARD_CLKS = 2,
    parameter int SUPER_LEN  = 19,
    parameter int SPARE_SLOT = 7,
    localparam int SLOT_W = $clog2(NUM_SLOTS),
    localparam int PER_W  = $clog2(SUPER_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 period_start,
    output logic [NUM_UNITS-1:0] src_grant,
    output logic [NUM_UNITS-1:0] dst_grant,
    output logic [SLOT_W-1:0]    slot_idx,
    output logic [PER_W-1:0]     period_idx,
    output logic                 guard,
    output logic                 in_period,
    output logic                 overrun
);
    logic grant_en;

    tdm_slot_timer #(
        .NUM_SLOTS (NUM_SLOTS),
        .SLOT_CLKS (SLOT_CLKS),
        .GUARD_CLKS(GUARD_CLKS)
    ) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (period_start),
        .active (in_period),
        .slot   (slot_idx),
        .guard  (guard),
        .overrun(overrun)
    );

    tdm_period_counter #(
        .SUPER_LEN(SUPER_LEN)
    ) u_period (
        .clk   (clk),
        .rst   (rst),
        .start (period_start),
        .period(period_idx)
    );

    assign grant_en = in_period && !guard;

    tdm_owner_lookup #(
        .NUM_SLOTS (NUM_SLOTS),
        .SUPER_LEN (SUPER_LEN),
        .SPARE_SLOT(SPARE_SLOT)
    ) u_lookup (
        .clk      (clk),
        .rst      (rst),
        .enable   (grant_en),
        .slot     (slot_idx),
        .period   (period_idx),
        .src_grant(src_grant),
        .dst_grant(dst_grant)
    );

    AST_GUARD_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        guard |-> (src_grant == '0 && dst_grant == '0)); // R3

    AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
        !in_period |-> (src_grant == '0 && dst_grant == '0 && !guard)); // R2

endmodule

// File: tb/tb_tdm_slot_sequencer.sv
module tb_tdm_slot_sequencer;
    localparam int NS = 8, SC = 6, GC = 2, SL = 19, SP = 7;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       period_start = 1'b0;
    logic [3:0] src_grant, dst_grant;
    logic [2:0] slot_idx;
    logic [4:0] period_idx;
    logic       guard, in_period, overrun;

    int checks = 0;
    int errors = 0;
    int exp_per = SL - 1;

    always #10 clk = ~clk;

    tdm_slot_sequencer dut (
        .clk(clk), .rst(rst), .period_start(period_start),
        .src_grant(src_grant), .dst_grant(dst_grant), .slot_idx(slot_idx),
        .period_idx(period_idx), .guard(guard), .in_period(in_period),
        .overrun(overrun)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic int onehot(input int id);
        return (id == 0) ? 0 : (1 << (id - 1));
    endfunction

    function automatic int exp_src(input int s, input int p);
        if (s == SP) return (p % 3 == 0) ? 2 : (p % 3 == 1) ? 1 : 0;
        return (s % 2 == 0) ? 4 : 1;
    endfunction

    function automatic int exp_dst(input int s, input int p);
        if (s == SP) return (p % 3 == 0) ? 1 : (p % 3 == 1) ? 2 : 0;
        return (s % 2 == 0) ? 1 : 3;
    endfunction

    // Pulse the strobe; returns at the negedge after the accepting edge.
    task automatic pulse_start();
        @(negedge clk);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        exp_per = (exp_per == SL - 1) ? 0 : exp_per + 1;
    endtask

    // Walk one period clock by clock; optionally chain the next one on the last clock.
    task automatic walk_period(input bit chain);
        for (int s = 0; s < NS; s++) begin
            for (int t = 0; t < SC; t++) begin
                chk("R2", "slot_idx", slot_idx, s);
                chk("R2", "in_period", in_period, 1);
                chk("R3", "guard", guard, (t < GC) ? 1 : 0);
                if (s == SP) begin
                    chk("R5", "src_grant", src_grant, (t < GC) ? 0 : onehot(exp_src(s, exp_per)));
                    chk("R5", "dst_grant", dst_grant, (t < GC) ? 0 : onehot(exp_dst(s, exp_per)));
                end else begin
                    chk("R4", "src_grant", src_grant, (t < GC) ? 0 : onehot(exp_src(s, exp_per)));
                    chk("R4", "dst_grant", dst_grant, (t < GC) ? 0 : onehot(exp_dst(s, exp_per)));
                end
                if (chain && s == NS - 1 && t == SC - 1) period_start = 1'b1;
                @(negedge clk);
                period_start = 1'b0;
            end
        end
        if (chain) exp_per = (exp_per == SL - 1) ? 0 : exp_per + 1;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        exp_per = SL - 1;
        chk("R1", "in_period", in_period, 0);
        chk("R1", "guard", guard, 0);
        chk("R1", "overrun", overrun, 0);
        chk("R1", "src_grant", src_grant, 0);
        chk("R1", "dst_grant", dst_grant, 0);
        chk("R1", "slot_idx", slot_idx, 0);
        chk("R1", "period_idx", period_idx, SL - 1);
    endtask

    task automatic t_chained_periods();
        pulse_start();
        chk("R6", "period_idx", period_idx, 0);
        walk_period(1'b1);
        chk("R8", "period_idx", period_idx, exp_per);
        chk("R8", "overrun", overrun, 0);
        walk_period(1'b1);
        walk_period(1'b0);
        chk("R8", "overrun", overrun, 0);
        for (int i = 0; i < 4; i++) begin
            chk("R2", "idle in_period", in_period, 0);
            chk("R2", "idle src_grant", src_grant, 0);
            chk("R2", "idle dst_grant", dst_grant, 0);
            @(negedge clk);
        end
        chk("R6", "period_idx held", period_idx, 2);
    endtask

    task automatic t_wrap();
        while (exp_per != SL - 1) begin
            pulse_start();
            chk("R6", "period_idx step", period_idx, exp_per);
            repeat (NS * SC + 2) @(negedge clk);
        end
        chk("R6", "period_idx top", period_idx, SL - 1);
        pulse_start();
        chk("R6", "period_idx wrap", period_idx, 0);
        walk_period(1'b0);
        chk("R8", "overrun after isolated", overrun, 0);
    endtask

    task automatic t_overrun();
        pulse_start();
        repeat (3 * SC + 2) @(negedge clk);
        chk("R7", "mid slot_idx", slot_idx, 3);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        exp_per = (exp_per == SL - 1) ? 0 : exp_per + 1;
        chk("R7", "restart slot_idx", slot_idx, 0);
        chk("R7", "restart guard", guard, 1);
        chk("R7", "overrun set", overrun, 1);
        chk("R7", "period_idx", period_idx, exp_per);
        walk_period(1'b0);
        chk("R7", "overrun sticky", overrun, 1);
        // strobe one clock before the final clock also overruns
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        exp_per = SL - 1;
        pulse_start();
        repeat (NS * SC - 2) @(negedge clk);
        chk("R7", "pre-final slot", slot_idx, NS - 1);
        period_start = 1'b1;
        @(negedge clk);
        period_start = 1'b0;
        chk("R7", "overrun one early", overrun, 1);
        chk("R7", "restart slot", slot_idx, 0);
    endtask

    initial begin
        t_reset();
        t_chained_periods();
        t_wrap();
        t_overrun();
        t_reset();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule